// File: doc/BRIEF.md
# Weighted Bus Arbiter with Timed Priority Escalation

This block decides which of several requesters owns a shared memory bus for the next transaction slot. Requester 0 is a latency-critical processor. Requesters 1 to 4 are streaming and bridge ports that can escalate their priority: 1 is video input, 2 is video output, 3 is the host bridge and 4 is the variable-length decoder. Any further indices are bulk coprocessors. Under saturation, each requester's share of grants follows a 4-bit programmable weight. Slots that no weighted requester wants go to the processor first.

Each escalation-capable requester has a delay register counted in units of 16 clock cycles. When its pending request has waited that long, the requester overrides the weighted schedule. Every programmed number of transactions the arbiter inserts a refresh slot ahead of all requesters. Each slot keeps the bus busy for a fixed number of cycles before the next decision: 20 for a transaction, 19 for a refresh.

Top module: `wrr_raise_arbiter`

## Requirements
- R1: While reset is low and in the first cycle after it, `gnt` is all zero and `gntValid` and `refGnt` are low.
- R2: `gntValid` is a one-cycle strobe. While it is high `gnt` has exactly one bit set, and `gnt` is zero otherwise.
- R3: Under full load, grants are served in rounds. Each requester gets as many grants per round as its weight (`weightVec[4i+3:4i]` for requester i). Within a round, the lowest index with remaining credit wins.
- R4: A requester with weight 0 is served only when no active requester has a nonzero weight. Such a slot goes to requester 0 if it is requesting, otherwise to the lowest active index.
- R5: Requester i in 1..4 is promoted above the weighted schedule once its request has waited at least 16·D cycles, where D = `raiseDelay[8(i-1)+7:8(i-1)]`. D = 0 disables promotion, and other requesters are never promoted.
- R6: When several promoted requesters contend, the lowest index wins (video input, then video output, host bridge, decoder).
- R7: A requester's wait time restarts when it is granted or drops its request. A request withdrawn before its grant is never granted.
- R8: After a transaction grant the next slot starts no sooner than 20 cycles later, and after a refresh slot no sooner than 19 cycles later. On a saturated bus these are the exact gaps.
- R9: When `refInterval` is nonzero and that many transaction grants have been issued since the last refresh, the next slot is a refresh: `refGnt` pulses with `gnt` zero. `refInterval` = 0 disables refresh.
- R10: On an idle bus, a request present at a clock edge is granted at that edge, so `gntValid` is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqVec | input | NUM_REQ | Request lines, bit 0 is the processor |
| weightVec | input | NUM_REQ*WEIGHT_W | Per-requester weights, 4 bits each |
| raiseDelay | input | RAISE_N*RAISE_W | Escalation delays for requesters 1..4, units of 16 cycles |
| refInterval | input | REF_W | Transactions between refresh slots, 0 disables |
| gnt | output | NUM_REQ | One-hot grant, valid with gntValid |
| gntValid | output | 1 | Grant strobe |
| refGnt | output | 1 | Refresh slot strobe |

## Verification
The assertions assume that a request stays high until it is granted or deliberately withdrawn. They also assume that the weight, delay and refresh-interval inputs change only while reset is held, so credits and timers never see a configuration change mid-round. The bench reprograms those inputs only inside its reset task and drives requests on the falling edge. This keeps every request decision tied to one rising edge. The grant-origin and promotion checks rely on that to compare a grant with the request vector sampled on the edge that produced it.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // Strobes from the selection control to the datapath registers
  typedef struct packed {
    logic issue;     // a slot starts at this edge
    logic refresh;   // the slot is a refresh slot
    logic weighted;  // grant charged against the weighted schedule
    logic reload;    // start a new round of credits
  } arbStrobe_t;
endpackage

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int NUM_REQ   = 6,
  parameter int WEIGHT_W  = 4,
  parameter int RAISE_N   = 4,
  parameter int RAISE_LO  = 1,
  parameter int RAISE_W   = 8,
  parameter int UNIT_LOG  = 4,
  parameter int REF_W     = 8,
  parameter int TXN_LEN   = 20,
  parameter int REF_LEN   = 19
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_REQ-1:0]          reqVec,
  input  logic [NUM_REQ*WEIGHT_W-1:0] weightVec,
  input  logic [RAISE_N*RAISE_W-1:0]  raiseDelay,
  input  logic [REF_W-1:0]            refInterval,
  input  arbStrobe_t                  strobe,
  input  logic [NUM_REQ-1:0]          sel,
  output logic                        free,
  output logic                        refDue,
  output logic [NUM_REQ-1:0]          creditNz,
  output logic [NUM_REQ-1:0]          weightNz,
  output logic [NUM_REQ-1:0]          expired,
  output logic [NUM_REQ-1:0]          gnt,
  output logic                        gntValid,
  output logic                        refGnt
);
  localparam int BUSY_W = $clog2(TXN_LEN > REF_LEN ? TXN_LEN : REF_LEN);
  localparam int WAIT_W = RAISE_W + UNIT_LOG;

  logic [BUSY_W-1:0] busyCnt;
  logic [REF_W-1:0]  txnCnt;

  assign free   = (busyCnt == '0);
  assign refDue = (refInterval != '0) && (txnCnt >= refInterval);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt  <= '0;
      txnCnt   <= '0;
      gnt      <= '0;
      gntValid <= 1'b0;
      refGnt   <= 1'b0;
    end else begin
      gnt      <= '0;
      gntValid <= 1'b0;
      refGnt   <= 1'b0;
      if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
      if (strobe.issue) begin
        if (strobe.refresh) begin
          refGnt  <= 1'b1;
          busyCnt <= BUSY_W'(REF_LEN - 1);
          txnCnt  <= '0;
        end else begin
          gnt      <= sel;
          gntValid <= 1'b1;
          busyCnt  <= BUSY_W'(TXN_LEN - 1);
          if (txnCnt != '1) txnCnt <= txnCnt + 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
    logic [WEIGHT_W-1:0] wgt;
    logic [WEIGHT_W-1:0] credit;
    assign wgt         = weightVec[i*WEIGHT_W +: WEIGHT_W];
    assign weightNz[i] = (wgt != '0);
    assign creditNz[i] = (credit != '0);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        credit <= '0;
      end else if (strobe.issue && strobe.weighted) begin
        if (strobe.reload)
          credit <= (sel[i] && wgt != '0) ? wgt - 1'b1 : wgt;
        else if (sel[i] && credit != '0)
          credit <= credit - 1'b1;
      end
    end

    if (i >= RAISE_LO && i < RAISE_LO + RAISE_N) begin : g_raise
      logic [WAIT_W-1:0]  waitCnt;
      logic [RAISE_W-1:0] dly;
      logic               granted;
      assign dly     = raiseDelay[(i-RAISE_LO)*RAISE_W +: RAISE_W];
      assign granted = strobe.issue && !strobe.refresh && sel[i];
      assign expired[i] = (dly != '0) && (waitCnt >= {dly, UNIT_LOG'(0)});

      always_ff @(posedge clk) begin
        if (!rstN || !reqVec[i] || granted) waitCnt <= '0;
        else if (waitCnt != '1)            waitCnt <= waitCnt + 1'b1;
      end

      // R7
      wait_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
        !reqVec[i] |=> (waitCnt == '0));
    end else begin : g_fixed
      assign expired[i] = 1'b0;
    end
  end

  // R2
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    gntValid |-> $onehot(gnt));
  // R2
  strobe_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    gntValid |=> !gntValid);
  // R2
  gnt_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !gntValid |-> (gnt == '0));
  // R9
  ref_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    refGnt |-> (gnt == '0 && !gntValid));
  // R7
  gnt_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    gntValid |-> ((gnt & $past(reqVec)) != '0));
  // R8
  slot_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gntValid || refGnt) |=> (!gntValid && !refGnt));
endmodule

// File: rtl/arb_ctl.sv
module arb_ctl
  import arb_pkg::*;
#(
  parameter int NUM_REQ = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] reqVec,
  input  logic               free,
  input  logic               refDue,
  input  logic [NUM_REQ-1:0] creditNz,
  input  logic [NUM_REQ-1:0] weightNz,
  input  logic [NUM_REQ-1:0] expired,
  output arbStrobe_t         strobe,
  output logic [NUM_REQ-1:0] sel
);
  function automatic logic [NUM_REQ-1:0] lowest(input logic [NUM_REQ-1:0] v);
    logic [NUM_REQ-1:0] r;
    r = '0;
    for (int i = NUM_REQ - 1; i >= 0; i--)
      if (v[i]) begin
        r    = '0;
        r[i] = 1'b1;
      end
    return r;
  endfunction

  logic [NUM_REQ-1:0] promoAct, creditAct, weightAct;
  assign promoAct  = reqVec & expired;
  assign creditAct = reqVec & creditNz;
  assign weightAct = reqVec & weightNz;

  always_comb begin
    strobe = '0;
    sel    = '0;
    if (free) begin
      if (refDue) begin
        strobe.issue   = 1'b1;
        strobe.refresh = 1'b1;
      end else if (promoAct != '0) begin
        strobe.issue = 1'b1;
        sel          = lowest(promoAct);
      end else if (creditAct != '0) begin
        strobe.issue    = 1'b1;
        strobe.weighted = 1'b1;
        sel             = lowest(creditAct);
      end else if (reqVec != '0) begin
        strobe.issue    = 1'b1;
        strobe.weighted = 1'b1;
        strobe.reload   = 1'b1;
        if (weightAct != '0)  sel = lowest(weightAct);
        else if (reqVec[0])   sel = NUM_REQ'(1);
        else                  sel = lowest(reqVec);
      end
    end
  end

  // R8
  no_issue_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !free |-> !strobe.issue);
  // R5
  promote_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && !strobe.refresh && promoAct != '0) |-> ((sel & promoAct) != '0));
  // R9
  refresh_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (free && refDue) |-> (strobe.refresh && sel == '0));
  // R4
  idle_cpu_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && strobe.reload && weightAct == '0 && reqVec[0]) |-> sel[0]);
endmodule

// File: rtl/wrr_raise_arbiter.sv
module wrr_raise_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_REQ  = 6,
  parameter int WEIGHT_W = 4,
  parameter int RAISE_N  = 4,
  parameter int RAISE_W  = 8,
  parameter int REF_W    = 8,
  parameter int TXN_LEN  = 20,
  parameter int REF_LEN  = 19
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_REQ-1:0]          reqVec,
  input  logic [NUM_REQ*WEIGHT_W-1:0] weightVec,
  input  logic [RAISE_N*RAISE_W-1:0]  raiseDelay,
  input  logic [REF_W-1:0]            refInterval,
  output logic [NUM_REQ-1:0]          gnt,
  output logic                        gntValid,
  output logic                        refGnt
);
  arbStrobe_t         strobe;
  logic [NUM_REQ-1:0] sel, creditNz, weightNz, expired;
  logic               free, refDue;

  arb_ctl #(.NUM_REQ(NUM_REQ)) ctl_i (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .free(free), .refDue(refDue),
    .creditNz(creditNz), .weightNz(weightNz), .expired(expired),
    .strobe(strobe), .sel(sel)
  );

  arb_datapath #(
    .NUM_REQ(NUM_REQ), .WEIGHT_W(WEIGHT_W), .RAISE_N(RAISE_N), .RAISE_LO(1),
    .RAISE_W(RAISE_W), .UNIT_LOG(4), .REF_W(REF_W),
    .TXN_LEN(TXN_LEN), .REF_LEN(REF_LEN)
  ) dp_i (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .weightVec(weightVec),
    .raiseDelay(raiseDelay), .refInterval(refInterval), .strobe(strobe),
    .sel(sel), .free(free), .refDue(refDue), .creditNz(creditNz),
    .weightNz(weightNz), .expired(expired), .gnt(gnt),
    .gntValid(gntValid), .refGnt(refGnt)
  );
endmodule

// File: tb/wrr_raise_arbiter_tb_top.sv
module wrr_raise_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic [5:0]  reqVec;
  logic [23:0] weightVec;
  logic [31:0] raiseDelay;
  logic [7:0]  refInterval;
  logic [5:0]  gnt;
  logic        gntValid, refGnt;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wrr_raise_arbiter dut_i (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .weightVec(weightVec),
    .raiseDelay(raiseDelay), .refInterval(refInterval),
    .gnt(gnt), .gntValid(gntValid), .refGnt(refGnt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setW(input int i, input int w);
    weightVec[i*4 +: 4] = 4'(w);
  endtask

  task automatic setD(input int i, input int d);
    raiseDelay[(i-1)*8 +: 8] = 8'(d);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    reqVec = '0;
    weightVec = '0;
    raiseDelay = '0;
    refInterval = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic release_();
    rstN = 1'b1;
  endtask

  // Waits for the next slot; who = requester index, -1 for refresh, -2 if none
  task automatic nextSlot(output int who, output int gap);
    who = -2;
    gap = 0;
    while (gap < 300) begin
      @(negedge clk);
      gap++;
      if (refGnt) begin who = -1; break; end
      if (gntValid) begin
        for (int k = 0; k < 6; k++) if (gnt[k]) who = k;
        break;
      end
    end
  endtask

  task automatic testReset();
    doReset();
    chk("R1 gnt in reset", int'(gnt), 0);
    chk("R1 gntValid in reset", int'(gntValid), 0);
    release_();
    @(negedge clk);
    chk("R1 refGnt after reset", int'(refGnt), 0);
    chk("R1 gntValid after reset", int'(gntValid), 0);
  endtask

  task automatic testLatency();
    int who, gap;
    doReset();
    setW(0, 2);
    release_();
    @(negedge clk);
    reqVec[0] = 1'b1;
    nextSlot(who, gap);
    chk("R10 first grant index", who, 0);
    chk("R10 idle-bus grant delay", gap, 1);
    chk("R2 grant one-hot value", int'(gnt), 1);
    @(negedge clk);
    chk("R2 strobe lasts one cycle", int'(gntValid), 0);
    nextSlot(who, gap);
    chk("R8 gap after transaction", gap, 19);
  endtask

  task automatic testProportion();
    int who, gap;
    int cnt[6];
    int gapBad;
    doReset();
    setW(0, 3); setW(1, 1); setW(2, 2); setW(3, 1); setW(4, 0); setW(5, 2);
    release_();
    @(negedge clk);
    reqVec = 6'h3f;
    foreach (cnt[k]) cnt[k] = 0;
    gapBad = 0;
    for (int n = 0; n < 18; n++) begin
      nextSlot(who, gap);
      if (who >= 0) cnt[who]++;
      if (n > 0 && gap != 20) gapBad++;
    end
    chk("R3 processor share", cnt[0], 6);
    chk("R3 requester1 share", cnt[1], 2);
    chk("R3 requester2 share", cnt[2], 4);
    chk("R3 requester3 share", cnt[3], 2);
    chk("R4 weight-zero starved under load", cnt[4], 0);
    chk("R3 requester5 share", cnt[5], 4);
    chk("R8 saturated gaps of 20", gapBad, 0);
  endtask

  task automatic testIdle();
    int who, gap;
    int bad;
    doReset();
    release_();
    @(negedge clk);
    reqVec = 6'b100001;
    bad = 0;
    for (int n = 0; n < 3; n++) begin
      nextSlot(who, gap);
      if (who != 0) bad++;
    end
    chk("R4 idle slots go to processor", bad, 0);
    reqVec = 6'b100000;
    nextSlot(who, gap);
    chk("R4 lone weight-zero requester served", who, 5);
    doReset();
    setW(2, 2);
    release_();
    @(negedge clk);
    reqVec = 6'b000101;
    bad = 0;
    for (int n = 0; n < 4; n++) begin
      nextSlot(who, gap);
      if (who != 2) bad++;
    end
    chk("R4 weighted requester beats weight-zero processor", bad, 0);
  endtask

  task automatic testRaise();
    int who, gap;
    int seen;
    doReset();
    setW(0, 15);
    release_();
    @(negedge clk);
    reqVec = 6'b001001;
    seen = 0;
    for (int n = 0; n < 5; n++) begin
      nextSlot(who, gap);
      if (who == 3) seen++;
    end
    chk("R5 delay zero never promotes", seen, 0);
    doReset();
    setW(0, 15);
    setD(3, 1);
    release_();
    @(negedge clk);
    reqVec = 6'b001001;
    nextSlot(who, gap);
    chk("R5 processor first before expiry", who, 0);
    nextSlot(who, gap);
    chk("R5 promoted after 16 cycles", who, 3);
  endtask

  task automatic testOrder();
    int who, gap;
    doReset();
    setW(0, 15);
    setD(1, 1); setD(2, 1); setD(3, 1); setD(4, 1);
    release_();
    @(negedge clk);
    reqVec = 6'b011111;
    nextSlot(who, gap);
    chk("R6 processor before expiry", who, 0);
    nextSlot(who, gap);
    chk("R6 video input wins promotion", who, 1);
    reqVec[1] = 1'b0;
    nextSlot(who, gap);
    chk("R6 video output next", who, 2);
    reqVec[2] = 1'b0;
    nextSlot(who, gap);
    chk("R6 host bridge next", who, 3);
  endtask

  task automatic testWithdraw();
    int who, gap;
    doReset();
    setW(0, 15);
    setD(4, 2);
    release_();
    @(negedge clk);
    reqVec = 6'b010001;
    nextSlot(who, gap);
    chk("R7 processor first", who, 0);
    repeat (15) @(negedge clk);
    reqVec[4] = 1'b0;
    nextSlot(who, gap);
    chk("R7 withdrawn request not granted", who, 0);
    reqVec[4] = 1'b1;
    nextSlot(who, gap);
    chk("R7 timer restarted after withdrawal", who, 0);
    nextSlot(who, gap);
    chk("R5 promoted after 32 cycles", who, 4);
  endtask

  task automatic testRefresh();
    int who, gap;
    doReset();
    setW(0, 4);
    refInterval = 8'd2;
    release_();
    @(negedge clk);
    reqVec = 6'b000001;
    nextSlot(who, gap);
    chk("R9 first transaction", who, 0);
    nextSlot(who, gap);
    chk("R9 second transaction", who, 0);
    nextSlot(who, gap);
    chk("R9 refresh after interval", who, -1);
    chk("R9 gnt zero during refresh", int'(gnt), 0);
    chk("R8 gap before refresh", gap, 20);
    nextSlot(who, gap);
    chk("R8 gap after refresh", gap, 19);
    chk("R9 transaction after refresh", who, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    reqVec = '0;
    weightVec = '0;
    raiseDelay = '0;
    refInterval = '0;
    testReset();
    testLatency();
    testProportion();
    testIdle();
    testRaise();
    testOrder();
    testWithdraw();
    testRefresh();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule